// File: doc/BRIEF.md
# Floating-Point Compare Condition Code Unit

This block compares two IEEE-754 operands and records the outcome as a 2-bit condition code in a 64-bit floating-point status word. The operands are either a single-precision pair, taken from the low 32 bits of each operand port, or a double-precision pair using all 64 bits. A 2-bit selector picks which of four condition fields receives the code. The comparison is purely combinational. The status word is updated through a register on a one-cycle valid strobe.

Only the selected field changes, together with the invalid accrued flag when it applies. Every other status bit is copied unchanged from the supplied status word. An unordered result, meaning either operand is a NaN, is handled in one of two ways, chosen by the invalid-trap-enable bit of that same status word. With the bit set, the block raises a one-cycle trap request. With the bit clear, it sets a sticky accrued flag instead.

Top module: `fpcc_unit`

## Requirements
- R1: The condition code is 2'b00 when the operands are equal, 2'b01 when operand A is less than B, 2'b10 when A is greater than B, and 2'b11 when the pair is unordered.
- R2: The selector value 0, 1, 2 or 3 writes the code into status bits 11:10, 33:32, 35:34 or 37:36 respectively; the written field is cleared before the new code goes in.
- R3: On an update, every status bit outside the selected field and the accrued flag (bit 9) equals the corresponding bit of `status_in`.
- R4: On an unordered result with the invalid-trap-enable bit (bit 27) of `status_in` set, the field receives 2'b11, `trap_out` is 1, and bit 9 is copied unchanged.
- R5: On an unordered result with bit 27 of `status_in` clear, the field receives 2'b11, bit 9 of the result is 1, and `trap_out` stays 0.
- R6: When `dbl_in` is 0, only bits 31:0 of each operand are compared as single precision and bits 63:32 have no effect; when `dbl_in` is 1, all 64 bits are compared as double precision.
- R7: Positive and negative zero compare equal. An operand is a NaN only if its exponent is all ones and its mantissa is nonzero, so infinities compare as ordered values.
- R8: `status_out` and `trap_out` take their new values on the rising clock edge where `valid_in` is 1. Without `valid_in`, `status_out` holds its value, `trap_out` is 0, and the inputs have no effect. The trap request lasts one cycle.
- R9: A synchronous active-high reset clears `status_out` to zero and `trap_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | One-cycle strobe that commits a comparison |
| dbl_in | input | 1 | 1 selects double precision, 0 selects single precision |
| sel_in | input | 2 | Selects the condition field to be written |
| opa_in | input | 64 | Operand A |
| opb_in | input | 64 | Operand B |
| status_in | input | 64 | Current status word that the update is based on |
| status_out | output | 64 | Registered updated status word |
| trap_out | output | 1 | One-cycle floating-point exception request |

## Verification
The assertions that look back one cycle assume that `valid_in` is low while reset is held and that it is never X after reset. The bench keeps to this by driving `valid_in` to 0 from time zero and changing inputs only on falling edges. The field and preservation checks accept any selector value and any status word, so the random stimulus draws both from their full ranges. Operands are drawn from a mix of random patterns, equal copies, sign flips, signed zeros, infinities and NaNs. This mix reaches every code in both precisions, and in single precision the upper 32 bits are filled with noise.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    localparam int SR_W = 64;

    typedef enum logic [1:0] {
        CC_EQ = 2'b00,
        CC_LT = 2'b01,
        CC_GT = 2'b10,
        CC_UN = 2'b11
    } cc_e;

    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic            trap;
    } upd_t;

    // Low bit position of condition field 'sel'
    function automatic int fld_lsb(input logic [1:0] sel, input int base, input int gap);
        if (sel == 2'd0) return base;
        return base + gap + 2 * (int'(sel) - 1);
    endfunction

endpackage

// File: rtl/fpcc_cmp.sv
module fpcc_cmp
    import fpcc_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    output cc_e                  cc
);
    localparam int W   = 1 + EXP_W + MAN_W;
    localparam int MGW = EXP_W + MAN_W;

    logic           sa, sb, nan_a, nan_b;
    logic [MGW-1:0] ma, mb;

    assign sa    = a[W-1];
    assign sb    = b[W-1];
    assign ma    = a[MGW-1:0];
    assign mb    = b[MGW-1:0];
    assign nan_a = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
    assign nan_b = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);

    always_comb begin
        if (nan_a || nan_b)
            cc = CC_UN;
        else if (ma == '0 && mb == '0)
            cc = CC_EQ;
        else if (sa != sb)
            cc = sa ? CC_LT : CC_GT;
        else if (ma == mb)
            cc = CC_EQ;
        else if ((ma < mb) ^ sa)
            cc = CC_LT;
        else
            cc = CC_GT;
    end

    // R7: signed zeros give equal; R1: a NaN forces unordered
    always_comb begin
        if (!nan_a && !nan_b && ma == '0 && mb == '0)
            p_zero_eq_r7: assert (cc == CC_EQ);
        if (nan_a)
            p_nan_un_r1: assert (cc == CC_UN);
    end

endmodule

// File: rtl/fpcc_upd.sv
module fpcc_upd
    import fpcc_pkg::*;
#(
    parameter int F0_POS = 10,
    parameter int F_GAP  = 22,
    parameter int TE_BIT = 27,
    parameter int AX_BIT = 9
) (
    input  logic [SR_W-1:0] sr_in,
    input  cc_e             cc,
    input  logic [1:0]      sel,
    output upd_t            upd
);
    logic [SR_W-1:0] fmask;
    int              lsb;

    always_comb begin
        lsb           = fld_lsb(sel, F0_POS, F_GAP);
        fmask         = {{(SR_W-2){1'b0}}, 2'b11} << lsb;
        upd.sr        = (sr_in & ~fmask) | ({{(SR_W-2){1'b0}}, cc} << lsb);
        upd.trap      = 1'b0;
        if (cc == CC_UN) begin
            if (sr_in[TE_BIT])
                upd.trap = 1'b1;
            else
                upd.sr[AX_BIT] = 1'b1;
        end
    end

    // R4/R5: a trap needs both an unordered code and an enabled trap
    always_comb begin
        if (upd.trap)
            p_trap_src_r4: assert (cc == CC_UN && sr_in[TE_BIT]);
    end

endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
    import fpcc_pkg::*;
#(
    parameter int F0_POS = 10,
    parameter int F_GAP  = 22,
    parameter int TE_BIT = 27,
    parameter int AX_BIT = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid_in,
    input  logic            dbl_in,
    input  logic [1:0]      sel_in,
    input  logic [63:0]     opa_in,
    input  logic [63:0]     opb_in,
    input  logic [SR_W-1:0] status_in,
    output logic [SR_W-1:0] status_out,
    output logic            trap_out
);
    localparam int N_PREC = 2;
    localparam int EXP_W [N_PREC] = '{8, 11};
    localparam int MAN_W [N_PREC] = '{23, 52};

    cc_e  cc_p [N_PREC];
    cc_e  cc_sel;
    upd_t nxt;

    for (genvar p = 0; p < N_PREC; p++) begin : g_prec
        localparam int OW = 1 + EXP_W[p] + MAN_W[p];
        fpcc_cmp #(.EXP_W(EXP_W[p]), .MAN_W(MAN_W[p])) u_cmp (
            .a  (opa_in[OW-1:0]),
            .b  (opb_in[OW-1:0]),
            .cc (cc_p[p])
        );
    end

    assign cc_sel = dbl_in ? cc_p[1] : cc_p[0];

    fpcc_upd #(.F0_POS(F0_POS), .F_GAP(F_GAP), .TE_BIT(TE_BIT), .AX_BIT(AX_BIT)) u_upd (
        .sr_in (status_in),
        .cc    (cc_sel),
        .sel   (sel_in),
        .upd   (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_out <= '0;
            trap_out   <= 1'b0;
        end else if (valid_in) begin
            status_out <= nxt.sr;
            trap_out   <= nxt.trap;
        end else begin
            trap_out   <= 1'b0;
        end
    end

    // Bits the update may not touch: all but the selected field and accrued flag
    function automatic logic [SR_W-1:0] keep_mask(input logic [1:0] s);
        logic [SR_W-1:0] m;
        m = ~({{(SR_W-2){1'b0}}, 2'b11} << fld_lsb(s, F0_POS, F_GAP));
        m[AX_BIT] = 1'b0;
        return m;
    endfunction

    p_keep_r3: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> (((status_out ^ $past(status_in)) & keep_mask($past(sel_in))) == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(status_out) && !trap_out));

    p_trap_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        trap_out |-> $past(valid_in));

    p_trap_field_r4: assert property (@(posedge clk) disable iff (rst)
        trap_out |-> (status_out[fld_lsb($past(sel_in), F0_POS, F_GAP) +: 2] == 2'b11
                      && status_out[TE_BIT]));

endmodule

// File: tb/sim_fpcc_unit.sv
`timescale 1ns/1ps
module sim_fpcc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic        dbl_in = 1'b0;
    logic [1:0]  sel_in = 2'd0;
    logic [63:0] opa_in = '0, opb_in = '0, status_in = '0;
    logic [63:0] status_out;
    logic        trap_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fpcc_unit u0 (
        .clk(clk), .rst(rst), .valid_in(valid_in), .dbl_in(dbl_in), .sel_in(sel_in),
        .opa_in(opa_in), .opb_in(opb_in), .status_in(status_in),
        .status_out(status_out), .trap_out(trap_out)
    );

    localparam logic [63:0] D_PZ  = 64'h0000_0000_0000_0000;
    localparam logic [63:0] D_NZ  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] D_ONE = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] D_TWO = 64'h4000_0000_0000_0000;
    localparam logic [63:0] D_INF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] D_NAN = 64'h7FF8_0000_0000_0001;
    localparam logic [31:0] S_ONE = 32'h3F80_0000;
    localparam logic [31:0] S_TWO = 32'h4000_0000;
    localparam logic [31:0] S_INF = 32'h7F80_0000;
    localparam logic [31:0] S_NAN = 32'h7FC0_0000;

    function automatic logic is_nan(input logic [63:0] x, input logic d);
        if (d) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    // signed integer key over sign-magnitude
    function automatic longint key(input logic [63:0] x, input logic d);
        longint m;
        logic s;
        s = d ? x[63] : x[31];
        m = d ? longint'({1'b0, x[62:0]}) : longint'({33'b0, x[30:0]});
        return s ? -m : m;
    endfunction

    function automatic logic [1:0] model_cc(input logic [63:0] a, input logic [63:0] b, input logic d);
        longint ka, kb;
        if (is_nan(a, d) || is_nan(b, d)) return 2'b11;
        ka = key(a, d);
        kb = key(b, d);
        if (ka == kb) return 2'b00;
        return (ka < kb) ? 2'b01 : 2'b10;
    endfunction

    function automatic int pos(input logic [1:0] s);
        case (s)
            2'd0: return 10;
            2'd1: return 32;
            2'd2: return 34;
            default: return 36;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One transaction: strobe, check the update, then check the hold cycle
    task automatic op(input string req, input logic [63:0] a, input logic [63:0] b,
                      input logic d, input logic [1:0] s, input logic [63:0] st);
        logic [1:0]  c;
        logic [63:0] e;
        logic        t;
        c = model_cc(a, b, d);
        e = st;
        e[pos(s) +: 2] = c;
        t = 1'b0;
        if (c == 2'b11) begin
            if (st[27]) t = 1'b1;
            else e[9] = 1'b1;
        end
        @(negedge clk);
        opa_in = a; opb_in = b; dbl_in = d; sel_in = s; status_in = st; valid_in = 1'b1;
        @(negedge clk);
        chk(req, status_out, e);
        chk(req, {63'b0, trap_out}, {63'b0, t});
        valid_in = 1'b0;
        status_in = {$urandom, $urandom};
        opa_in = {$urandom, $urandom};
        sel_in = sel_in + 2'd1;
        @(negedge clk);
        chk("R8 hold", status_out, e);
        chk("R8 pulse", {63'b0, trap_out}, 64'd0);
    endtask

    function automatic logic [63:0] gen(input int kind, input logic [63:0] o, input logic d);
        logic [63:0] r, noise;
        noise = {$urandom, 32'h0};
        r = {$urandom, $urandom};
        case (kind)
            0: ;
            1: r = o;
            2: r = d ? {~o[63], o[62:0]} : {o[63:32], ~o[31], o[30:0]};
            3: r = d ? {r[63], 63'b0} : {32'b0, r[31], 31'b0};
            4: r = d ? {r[63], D_INF[62:0]} : {32'b0, r[31], S_INF[30:0]};
            5: r = d ? {r[63], 11'h7FF, 1'b1, r[50:0]} : {32'b0, r[31], 8'hFF, 1'b1, r[21:0]};
            default: r = o + 64'd1;
        endcase
        if (!d) r = {noise[63:32], r[31:0]};
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R9 reset status", status_out, 64'd0);
        chk("R9 reset trap", {63'b0, trap_out}, 64'd0);
        rst = 1'b0;

        // R1 codes in double, each field for R2
        op("R1 eq", D_ONE, D_ONE, 1'b1, 2'd0, 64'd0);
        op("R1 lt", D_ONE, D_TWO, 1'b1, 2'd1, 64'd0);
        op("R1 gt", D_TWO, D_ONE, 1'b1, 2'd2, 64'd0);
        op("R1 neg lt", {1'b1, D_TWO[62:0]}, {1'b1, D_ONE[62:0]}, 1'b1, 2'd3, 64'd0);
        // R2 field cleared before write, others all ones (R3)
        for (int s = 0; s < 4; s++) begin
            op("R2 R3 field", D_ONE, D_TWO, 1'b1, 2'(s), ~64'd0 & ~(64'd1 << 27));
            op("R2 R3 field", D_TWO, D_ONE, 1'b0 | 1'b1, 2'(s), 64'h0123_4567_89AB_CDEF);
        end
        // R4 trap, R5 accrued
        op("R4 trap", D_NAN, D_ONE, 1'b1, 2'd2, 64'd1 << 27);
        op("R4 trap sp", {32'hFFFF_FFFF, S_NAN}, {32'h0, S_ONE}, 1'b0, 2'd0, (64'd1 << 27) | 64'h3F0);
        op("R5 accrued", D_ONE, D_NAN, 1'b1, 2'd3, 64'd0);
        op("R5 accrued sp", {32'h0, S_TWO}, {32'h0, S_NAN}, 1'b0, 2'd1, 64'hFFFF_0000_0000_0000);
        // R6 single ignores upper bits
        op("R6 upper ignored", {32'hFFFF_FFFF, S_ONE}, {32'h0000_0001, S_ONE}, 1'b0, 2'd0, 64'd0);
        op("R6 single lt", {32'h7FFF_FFFF, S_ONE}, {32'h0, S_TWO}, 1'b0, 2'd1, 64'd0);
        op("R6 double", {32'h0, S_TWO}, {32'h0, S_ONE}, 1'b1, 2'd1, 64'd0);
        // R7 zeros, infinities
        op("R7 pz nz", D_PZ, D_NZ, 1'b1, 2'd0, 64'd0);
        op("R7 nz pz sp", {32'h0, 32'h8000_0000}, 64'd0, 1'b0, 2'd2, 64'd0);
        op("R7 inf ordered", D_INF, D_ONE, 1'b1, 2'd0, 64'd1 << 27);
        op("R7 inf eq", {32'h0, S_INF}, {32'h0, S_INF}, 1'b0, 2'd3, 64'd1 << 27);
        op("R7 ninf lt", {1'b1, D_INF[62:0]}, D_NZ, 1'b1, 2'd1, 64'd0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic        d;
            logic [63:0] a, b;
            d = 1'($urandom);
            a = gen(int'($urandom % 6) == 1 ? 0 : int'($urandom % 6), 64'd0, d);
            b = gen(int'($urandom % 7), a, d);
            op(d ? "R1 R3 random dp" : "R1 R6 random sp", a, b, d, 2'($urandom),
               {$urandom, $urandom});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule